// File: doc/BRIEF.md
# SPI Master Channel Transfer Engine

This block is one channel of a multi-channel SPI master. It keeps a configuration word, an enable bit, a transmit holding register, a receive holding register and three status flags. When an attempt is made, the channel checks its flags, its direction mode and its turbo option. If these allow it, the channel copies the transmit word into a shifter and exchanges one word on the SPI pins. The exchange is MSB first, in clock mode 0, with a word length of 1 to 32 bits set by the configuration.

An attempt is made on three events: a write of the transmit register, a read of the receive register, or a 0-to-1 write of the enable bit. When the exchange ends, the status flags are updated. The channel then drives separate transmit and receive DMA request lines, and sends one-cycle notification pulses to a shared interrupt collector.

A chip-level input selects multi-channel operation. If that input is low and the channel's forced chip-select bit is clear, an allowed attempt finishes at once and nothing moves on the wire.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset, the status reads 0x2 (bit 0 receive-full, bit 1 transmit-empty, bit 2 end-of-transfer), the configuration reads 0x060000, the enable reads 0, chip-select is high, SCLK is low, and both DMA requests are low.
- R2: A configuration write keeps bits 22:0 and reads back zero above them. The fields are: word length at 11:7 (length = value + 1), direction mode at 13:12, TX DMA enable at 14, RX DMA enable at 15, turbo at 19, forced chip-select at 20.
- R3: An exchange drives MOSI MSB first and samples MISO on each SCLK rising edge, with SCLK idle low and one SCLK period every 4 clocks. Chip-select stays low for the whole word. The received bits land right-aligned in the receive register, with zeros above them.
- R4: No exchange starts while the channel is disabled.
- R5: With receive-full set, no exchange starts, unless the mode is transmit-only or turbo (bit 19) is set.
- R6: With transmit-empty set, no exchange starts, unless the mode is receive-only. In receive-only mode, an exchange starts without any transmit write.
- R7: Starting an exchange clears end-of-transfer. Completion sets end-of-transfer and transmit-empty, and sets receive-full unless the mode is transmit-only (mode 2).
- R8: A transmit write clears transmit-empty, a receive read clears receive-full, and a 0-to-1 enable write leaves the flags as they are. Each of the three then attempts an exchange.
- R9: With the multi-channel input low and forced chip-select clear, an allowed attempt moves nothing on the wire. It still sets the completion flags and leaves the receive register unchanged.
- R10: The TX DMA request is high when: enabled, bit 14 set, transmit-empty, and mode not receive-only. The RX DMA request is high when: enabled, bit 15 set, receive-full, and mode not transmit-only.
- R11: At completion, a one-cycle transmit-empty pulse is emitted unless the mode is receive-only. A one-cycle receive-full pulse is emitted unless the mode is transmit-only or turbo is set.
- R12: Modes 0 and 3 both run full duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| multi_mode | input | 1 | Chip-level multi-channel operation select |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write value |
| en_rdata | output | 1 | Current enable |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_wdata | input | DATA_W | Transmit word |
| rx_rd | input | 1 | Receive register read strobe |
| rx_rdata | output | DATA_W | Receive holding register |
| status | output | 3 | {end-of-transfer, transmit-empty, receive-full} |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq_tx_empty | output | 1 | Transmit-empty notification pulse |
| irq_rx_full | output | 1 | Receive-full notification pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
Suppose the pending attempt is lost, or a start-gate term is inverted. Then chip-select either fails to fall, or falls within two clocks of the triggering strobe when it should not, and end-of-transfer stays stale. A wrong bit counter or phase counter shows up one word later as a truncated or shifted receive value and a wrong MOSI capture. A wrong flag update is visible on the status and DMA pins in the cycle after completion. A notification pulse that is missing or doubled changes the pulse count taken in that same cycle.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
   localparam int BUS_W      = 32;
   localparam int CFG_BITS   = 23;
   localparam logic [CFG_BITS-1:0] CFG_RESET = 23'h060000;
   localparam int WL_LSB     = 7;
   localparam int WL_W       = 5;
   localparam int MODE_LSB   = 12;
   localparam int DMA_TX_BIT = 14;
   localparam int DMA_RX_BIT = 15;
   localparam int TURBO_BIT  = 19;
   localparam int FORCE_BIT  = 20;
   localparam int ST_RXF     = 0;
   localparam int ST_TXE     = 1;
   localparam int ST_EOT     = 2;

   typedef enum logic [1:0] {
      XM_DUPLEX  = 2'd0,
      XM_RX_ONLY = 2'd1,
      XM_TX_ONLY = 2'd2,
      XM_RSVD    = 2'd3
   } xfer_mode_e;

   typedef struct packed {
      logic            tx_dma;
      logic            rx_dma;
      logic            turbo;
      logic            force_cs;
      xfer_mode_e      mode;
      logic [WL_W-1:0] wl;
   } chan_cfg_t;

   function automatic chan_cfg_t cfg_fields(input logic [CFG_BITS-1:0] r);
      chan_cfg_t c;
      c.tx_dma   = r[DMA_TX_BIT];
      c.rx_dma   = r[DMA_RX_BIT];
      c.turbo    = r[TURBO_BIT];
      c.force_cs = r[FORCE_BIT];
      c.mode     = xfer_mode_e'(r[MODE_LSB +: 2]);
      c.wl       = r[WL_LSB +: WL_W];
      return c;
   endfunction
endpackage

// File: rtl/spi_chan_cfg.sv
module spi_chan_cfg
   import spi_chan_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [BUS_W-1:0]    cfg_wdata,
   input  logic                en_wr,
   input  logic                en_wdata,
   output logic [CFG_BITS-1:0] cfg_raw,
   output chan_cfg_t           cfg,
   output logic                en_q,
   output logic                en_rise
);
   initial begin
      assert (BUS_W >= CFG_BITS) else $error("config bus narrower than stored word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_raw <= CFG_RESET;
         en_q    <= 1'b0;
      end else begin
         if (cfg_wr) cfg_raw <= cfg_wdata[CFG_BITS-1:0];
         if (en_wr)  en_q    <= en_wdata;
      end
   end

   assign cfg     = cfg_fields(cfg_raw);
   assign en_rise = en_wr & en_wdata & ~en_q;
endmodule

// File: rtl/spi_chan_flags.sv
module spi_chan_flags
   import spi_chan_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chan_cfg_t         cfg,
   input  logic              en_q,
   input  logic              en_rise,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_rd,
   input  logic              busy,
   input  logic              xfer_done,
   input  logic              shifted,
   input  logic [DATA_W-1:0] rx_word,
   output logic [DATA_W-1:0] tx_hold,
   output logic [DATA_W-1:0] rx_hold,
   output logic [2:0]        status,
   output logic              start,
   output logic              tx_dma_req,
   output logic              rx_dma_req,
   output logic              irq_tx_p,
   output logic              irq_rx_p
);
   logic pend, rxf, txe, eot;
   logic rx_block, tx_block, gate, idle;

   assign rx_block = rxf && (cfg.mode != XM_TX_ONLY) && !cfg.turbo;
   assign tx_block = txe && (cfg.mode != XM_RX_ONLY);
   assign gate     = en_q && !rx_block && !tx_block;
   assign idle     = !busy && !xfer_done;
   assign start    = pend && idle && gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         rxf      <= 1'b0;
         txe      <= 1'b1;
         eot      <= 1'b0;
         tx_hold  <= '0;
         rx_hold  <= '0;
         irq_tx_p <= 1'b0;
         irq_rx_p <= 1'b0;
      end else begin
         if (tx_wr || rx_rd || en_rise) pend <= 1'b1;
         else if (idle)                 pend <= 1'b0;
         if (start) eot <= 1'b0;
         if (xfer_done) begin
            eot <= 1'b1;
            txe <= 1'b1;
            if (cfg.mode != XM_TX_ONLY) rxf <= 1'b1;
            if (shifted) rx_hold <= rx_word;
         end
         if (tx_wr) begin
            tx_hold <= tx_wdata;
            txe     <= 1'b0;
         end
         if (rx_rd) rxf <= 1'b0;
         irq_tx_p <= xfer_done && (cfg.mode != XM_RX_ONLY);
         irq_rx_p <= xfer_done && (cfg.mode != XM_TX_ONLY) && !cfg.turbo;
      end
   end

   assign status     = {eot, txe, rxf};
   assign tx_dma_req = en_q && cfg.tx_dma && txe && (cfg.mode != XM_RX_ONLY);
   assign rx_dma_req = en_q && cfg.rx_dma && rxf && (cfg.mode != XM_TX_ONLY);

   assert_eot_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> (status[ST_EOT] && (status[ST_TXE] || $past(tx_wr))));
   assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_p |=> !irq_rx_p);
endmodule

// File: rtl/spi_chan_shifter.sv
module spi_chan_shifter #(
   parameter int DATA_W   = 32,
   parameter int SCLK_DIV = 4,
   parameter int IDX_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              skip,
   input  logic [IDX_W-1:0]  len_m1,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              miso,
   output logic              busy,
   output logic              xfer_done,
   output logic              shifted,
   output logic [DATA_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);
   localparam int PH_W = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
   localparam int HALF = SCLK_DIV / 2;
   localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCLK_DIV - 1);

   initial begin
      assert (SCLK_DIV >= 2 && SCLK_DIV % 2 == 0) else $error("SCLK_DIV must be even and at least 2");
      assert (DATA_W >= 32) else $error("DATA_W must hold a 32-bit word");
   end

   logic              run;
   logic [PH_W-1:0]   ph;
   logic [IDX_W-1:0]  bitn, len_q;
   logic [DATA_W-1:0] sh_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         run       <= 1'b0;
         xfer_done <= 1'b0;
         shifted   <= 1'b0;
         cs_n      <= 1'b1;
         ph        <= '0;
         bitn      <= '0;
         len_q     <= '0;
         sh_tx     <= '0;
         rx_word   <= '0;
      end else begin
         xfer_done <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            run     <= !skip;
            cs_n    <= skip;
            ph      <= '0;
            bitn    <= '0;
            len_q   <= len_m1;
            sh_tx   <= tx_word;
            rx_word <= '0;
         end else if (busy && !run) begin
            busy      <= 1'b0;
            xfer_done <= 1'b1;
            shifted   <= 1'b0;
         end else if (run) begin
            ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
            if (ph == PH_RISE) rx_word <= {rx_word[DATA_W-2:0], miso};
            if (ph == PH_LAST) begin
               if (bitn == len_q) begin
                  busy      <= 1'b0;
                  run       <= 1'b0;
                  cs_n      <= 1'b1;
                  xfer_done <= 1'b1;
                  shifted   <= 1'b1;
               end else begin
                  bitn  <= bitn + 1'b1;
                  sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign sclk = run && (ph > PH_RISE);
   assign mosi = run && sh_tx[len_q];

   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   assert_cs_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> xfer_done);
endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
   import spi_chan_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SCLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              multi_mode,
   input  logic              cfg_wr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              en_wr,
   input  logic              en_wdata,
   output logic              en_rdata,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_rdata,
   output logic [2:0]        status,
   output logic              tx_dma_req,
   output logic              rx_dma_req,
   output logic              irq_tx_empty,
   output logic              irq_rx_full,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   localparam int IDX_W = $clog2(DATA_W);

   logic [CFG_BITS-1:0] cfg_raw;
   chan_cfg_t           cfg;
   logic                en_q, en_rise, start, busy, xfer_done, shifted;
   logic [DATA_W-1:0]   tx_hold, rx_word;
   logic [IDX_W-1:0]    len_m1;

   generate
      if (IDX_W > WL_W) begin : g_len_wide
         assign len_m1 = {{(IDX_W-WL_W){1'b0}}, cfg.wl};
      end else begin : g_len_exact
         assign len_m1 = cfg.wl;
      end
   endgenerate

   spi_chan_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .en_wr(en_wr), .en_wdata(en_wdata), .cfg_raw(cfg_raw), .cfg(cfg),
      .en_q(en_q), .en_rise(en_rise)
   );

   spi_chan_flags #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .en_q(en_q), .en_rise(en_rise),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .busy(busy),
      .xfer_done(xfer_done), .shifted(shifted), .rx_word(rx_word),
      .tx_hold(tx_hold), .rx_hold(rx_rdata), .status(status), .start(start),
      .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
      .irq_tx_p(irq_tx_empty), .irq_rx_p(irq_rx_full)
   );

   spi_chan_shifter #(.DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV), .IDX_W(IDX_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start),
      .skip(!(multi_mode || cfg.force_cs)), .len_m1(len_m1),
      .tx_word(tx_hold), .miso(spi_miso), .busy(busy), .xfer_done(xfer_done),
      .shifted(shifted), .rx_word(rx_word), .sclk(spi_sclk), .mosi(spi_mosi),
      .cs_n(spi_cs_n)
   );

   assign cfg_rdata = {{(32-CFG_BITS){1'b0}}, cfg_raw};
   assign en_rdata  = en_q;

   assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> $past(en_q));
   assert_dma_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req |-> (status[ST_TXE] && en_rdata));
   assert_dma_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> (status[ST_RXF] && en_rdata));
endmodule

// File: tb/spi_chan_engine_tb.sv
module spi_chan_engine_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [1:0]  mode;
      logic [4:0]  wl;
      logic [31:0] tx;
      logic [31:0] mi;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 5'd7,  32'h0000_00A5, 32'h0000_003C},
      '{2'd0, 5'd15, 32'h0000_1234, 32'h0000_BEEF},
      '{2'd1, 5'd11, 32'h0000_0000, 32'h0000_0ABC},
      '{2'd2, 5'd4,  32'h0000_0015, 32'h0000_0011},
      '{2'd0, 5'd31, 32'hDEAD_BEEF, 32'h0123_4567},
      '{2'd3, 5'd3,  32'h0000_0009, 32'h0000_0006}
   };

   logic clk = 1'b0, rst_n = 1'b0, multi_mode = 1'b1;
   logic cfg_wr = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
   logic [31:0] cfg_wdata = '0, tx_wdata = '0;
   logic [31:0] cfg_rdata, rx_rdata;
   logic        en_rdata, tx_dma_req, rx_dma_req, irq_tx_empty, irq_rx_full;
   logic        spi_sclk, spi_mosi, spi_cs_n;
   logic        spi_miso = 1'b0;
   logic [2:0]  status;

   int checks = 0, errors = 0, cycles = 0;
   int cs_falls = 0, n_irq_tx = 0, n_irq_rx = 0;
   logic cs_prev = 1'b1;
   int slv_len = 8;
   logic [31:0] slv_word = '0, slv_sh = '0, mosi_cap = '0;

   spi_chan_engine u_dut (
      .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en_wr(en_wr),
      .en_wdata(en_wdata), .en_rdata(en_rdata), .tx_wr(tx_wr),
      .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata), .status(status),
      .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
      .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      cs_prev <= spi_cs_n;
      if (cs_prev && !spi_cs_n) cs_falls <= cs_falls + 1;
      if (irq_tx_empty) n_irq_tx <= n_irq_tx + 1;
      if (irq_rx_full)  n_irq_rx <= n_irq_rx + 1;
   end

   // SPI slave model: mode 0, MSB first
   always @(negedge spi_cs_n) begin
      slv_sh   = slv_word;
      spi_miso = slv_sh[slv_len-1];
      mosi_cap = '0;
   end
   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         slv_sh   = slv_sh << 1;
         spi_miso = slv_sh[slv_len-1];
      end
   end
   always @(posedge spi_sclk) mosi_cap = {mosi_cap[30:0], spi_mosi};

   function automatic logic [31:0] lenmask(input int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask
   task automatic wr_en(input logic v);
      @(negedge clk); en_wr = 1'b1; en_wdata = v;
      @(negedge clk); en_wr = 1'b0;
   endtask
   task automatic wr_tx(input logic [31:0] v);
      @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
      @(negedge clk); tx_wr = 1'b0;
   endtask
   task automatic rd_rx();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wait_eot(input string req);
      int k;
      k = 0;
      repeat (3) @(negedge clk);
      while (!status[2] && k < 1000) begin
         @(negedge clk); k++;
      end
      if (!status[2]) chk(req, 32'(status), 32'h4);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
   end

   initial begin
      int f0, t0, r0;
      logic [31:0] rx_keep;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      chk("R1 status", 32'(status), 32'h2);
      chk("R1 cfg", cfg_rdata, 32'h0006_0000);
      chk("R1 pins", {28'd0, en_rdata, spi_cs_n, spi_sclk, tx_dma_req | rx_dma_req}, 32'h4);
      // R2: stored width
      wr_cfg(32'hFFFF_FFFF);
      chk("R2 store mask", cfg_rdata, 32'h007F_FFFF);

      // vector walk: R3, R6, R7, R11, R12
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         int   len;
         v = VECS[i];
         len = int'(v.wl) + 1;
         slv_len = len; slv_word = v.mi;
         t0 = n_irq_tx; r0 = n_irq_rx; f0 = cs_falls;
         wr_cfg({18'd0, v.mode, v.wl, 7'd0});
         wr_en(1'b1);
         if (v.mode != 2'd1) wr_tx(v.tx);
         wait_eot("R7 vector eot");
         chk("R3 one word", 32'(cs_falls - f0), 32'd1);
         chk("R7 status", 32'(status), (v.mode == 2'd2) ? 32'h6 : 32'h7);
         if (v.mode != 2'd2) chk("R3 rx word", rx_rdata, v.mi & lenmask(len));
         if (v.mode != 2'd1) chk("R3 R12 mosi", mosi_cap, v.tx & lenmask(len));
         chk("R11 tx pulse", 32'(n_irq_tx - t0), (v.mode != 2'd1) ? 32'd1 : 32'd0);
         chk("R11 rx pulse", 32'(n_irq_rx - r0), (v.mode != 2'd2) ? 32'd1 : 32'd0);
         wr_en(1'b0);
         rd_rx();
      end

      // R4: disabled channel does not start
      rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
      slv_len = 8; slv_word = 32'h96;
      wr_cfg(32'd7 << 7);
      f0 = cs_falls;
      wr_tx(32'h55);
      idle(50);
      chk("R4 no start", 32'(cs_falls - f0), 32'd0);
      chk("R4 R8 status", 32'(status), 32'h0);
      // R8: enable rising edge attempts
      wr_en(1'b1);
      wait_eot("R8 enable start");
      chk("R8 enable start", 32'(status), 32'h7);
      chk("R8 mosi", mosi_cap, 32'h55);

      // R5: receive-full blocks, receive read restarts
      f0 = cs_falls;
      wr_tx(32'h0F);
      idle(50);
      chk("R5 blocked", 32'(cs_falls - f0), 32'd0);
      chk("R5 status", 32'(status), 32'h5);
      rd_rx();
      wait_eot("R8 read start");
      chk("R8 read start", 32'(cs_falls - f0), 32'd1);
      chk("R8 read mosi", mosi_cap, 32'h0F);

      // R5: turbo lets a word start over receive-full
      wr_cfg((32'd1 << 19) | (32'd7 << 7));
      t0 = n_irq_tx; r0 = n_irq_rx; f0 = cs_falls;
      wr_tx(32'h33);
      wait_eot("R5 turbo");
      chk("R5 turbo start", 32'(cs_falls - f0), 32'd1);
      chk("R11 turbo rx pulse", 32'(n_irq_rx - r0), 32'd0);
      chk("R11 turbo tx pulse", 32'(n_irq_tx - t0), 32'd1);

      // R10: DMA requests (txe=1, rxf=1, enabled)
      wr_cfg((32'd3 << 14) | (32'd7 << 7));
      chk("R10 duplex", {30'd0, tx_dma_req, rx_dma_req}, 32'h3);
      wr_cfg((32'd3 << 14) | (32'd1 << 12) | (32'd7 << 7));
      chk("R10 rx only", {30'd0, tx_dma_req, rx_dma_req}, 32'h1);
      wr_cfg((32'd3 << 14) | (32'd2 << 12) | (32'd7 << 7));
      chk("R10 tx only", {30'd0, tx_dma_req, rx_dma_req}, 32'h2);
      wr_en(1'b0);
      chk("R10 disabled", {30'd0, tx_dma_req, rx_dma_req}, 32'h0);

      // R9: single-channel operation without forced chip-select
      rd_rx();
      multi_mode = 1'b0;
      wr_cfg(32'd7 << 7);
      wr_en(1'b1);
      rx_keep = rx_rdata;
      f0 = cs_falls;
      wr_tx(32'hAA);
      wait_eot("R9 silent");
      chk("R9 no wire", 32'(cs_falls - f0), 32'd0);
      chk("R9 flags", 32'(status), 32'h7);
      chk("R9 rx kept", rx_rdata, rx_keep);
      // R9: forced chip-select shifts in single-channel operation
      slv_word = 32'h5A;
      wr_cfg((32'd1 << 20) | (32'd7 << 7));
      rd_rx();
      wr_tx(32'hC3);
      wait_eot("R9 forced");
      chk("R9 forced wire", 32'(cs_falls - f0), 32'd1);
      chk("R9 forced rx", rx_rdata, 32'h5A);
      chk("R9 forced mosi", mosi_cap, 32'hC3);

      finish_run();
   end
endmodule